// File: doc/BRIEF.md
# Receive Buffer Resource Manager

This block places received frames into host memory buffers for a receive DMA engine. The host loads buffer entries, each a start address and a size in bus words, into a small circular table. The block takes frame bytes one per cycle and writes them to consecutive byte addresses in the current buffer. It then appends the 4-byte frame check sequence, least significant byte first, and fills the rest of the last bus word with 0xFF. When the frame is complete, the write address moves past everything that was written, and the remaining word count drops by the padded length.

When the space left in a buffer falls below a threshold, the block moves to the next table entry by itself. Taking the last entry raises an early warning, but frames are still received into that buffer. A separate exhausted flag, set only when a new buffer is needed and the table is empty, is the only thing that causes frames to be dropped. A frame that does not fit in the remaining space is discarded, and an oversize interrupt is raised. The bus width mode sets the word size (2 bytes or 4 bytes), the alignment of loaded buffer addresses and the pad boundary.

Top module: `rx_buf_manager`

## Requirements
- R1: After reset the exhausted flag is 1, the status and pending-load flag are 0, irq_o is 0, the remaining word count is 0, rx_ready_o is 1 and no memory write is issued.
- R2: Loading a table entry forces address bit 0 to zero in 16-bit mode and bits 1:0 to zero in 32-bit mode, takes its word count and increments the buffer sequence count.
- R3: A load command sets a pending flag that stays set while the table is empty and clears only in the cycle an entry is actually loaded.
- R4: Frame byte i is written to buffer address + i, followed by the 4 check bytes least significant first.
- R5: After the check bytes, 0xFF is written until the total written length is a multiple of 2 bytes (16-bit mode) or 4 bytes (32-bit mode).
- R6: After a stored frame, the buffer address advances by the padded length, the word count drops by ceil((L+4)/bytes-per-word), the frame sequence count increments and status bit 0 is set.
- R7: A frame with L+4 greater than the remaining bytes sets status bit 2 and leaves address, count and frame sequence unchanged. Only bytes whose index i satisfies i+5 <= capacity are written.
- R8: If the word count left after a frame is below EOB_WORDS, the next entry is loaded automatically. Loading the last table entry sets status bit 1, and frames are still accepted afterwards.
- R9: If a new buffer is needed and the table is empty, the exhausted flag is set. While it is set, frames produce no writes and no sequence change.
- R10: Status bits are sticky and cleared by writing 1 with reg_sel_i=2. The mask is written with reg_sel_i=3, and irq_o = OR(status AND mask).
- R11: reg_sel_i=0 stages an address and reg_sel_i=1 appends the staged address with the given word count. The table index wraps after DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode32_i | input | 1 | 1 selects 4-byte bus words, 0 selects 2-byte bus words |
| rx_valid_i | input | 1 | Receive byte valid |
| rx_sof_i | input | 1 | First byte of a frame |
| rx_eof_i | input | 1 | Last byte of a frame |
| rx_data_i | input | 8 | Receive byte |
| rx_fcs_i | input | 32 | Check sequence, valid with rx_eof_i |
| rx_ready_o | output | 1 | A new frame may start |
| reg_we_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select |
| reg_wdata_i | input | AW | Register write data |
| cmd_load_i | input | 1 | Load-next-buffer command pulse |
| mem_we_o | output | 1 | Memory byte write |
| mem_addr_o | output | AW | Memory byte address |
| mem_data_o | output | 8 | Memory byte data |
| irq_o | output | 1 | Masked interrupt |
| irq_status_o | output | 3 | Status bits: frame stored, early warning, oversize |
| cmd_pend_o | output | 1 | Load command pending |
| exhausted_o | output | 1 | No buffer available; frames are dropped |
| buf_addr_o | output | AW | Next write address |
| buf_words_o | output | CW | Remaining word count |
| pkt_seq_o | output | 8 | Stored-frame sequence count |
| buf_seq_o | output | 8 | Buffer-load sequence count |

## Verification
A wrong byte offset or pad count shows up at the memory port in the same frame, as a misplaced check byte or a missing 0xFF. A wrong address or word count update shows up on buf_addr_o and buf_words_o two cycles after the last tail write. A wrong table state shows up one frame later, as a load of the wrong address, an early warning that is missing or arrives at the wrong time, or a false exhausted flag. Such a false exhausted flag causes the next frame to be dropped silently.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  typedef enum logic [1:0] {WS_IDLE, WS_RECV, WS_DROP, WS_TAIL} wr_state_e;
  localparam int unsigned FCS_BYTES = 4;
  localparam logic [7:0]  PAD_BYTE  = 8'hFF;
  localparam int unsigned ST_PKT  = 0;
  localparam int unsigned ST_WARN = 1;
  localparam int unsigned ST_OVER = 2;
  localparam int unsigned ST_W    = 3;
endpackage

// File: rtl/rbm_desc_ring.sv
module rbm_desc_ring #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned AW    = 16,
  parameter int unsigned CW    = 12,
  parameter int unsigned CNTW  = $clog2(DEPTH + 1)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            stage_we_i,
  input  logic            push_i,
  input  logic [AW-1:0]   data_i,
  input  logic            pop_i,
  output logic [AW-1:0]   head_ptr_o,
  output logic [CW-1:0]   head_wc_o,
  output logic [CNTW-1:0] count_o
);
  localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [AW-1:0]   ptr_q [DEPTH];
  logic [CW-1:0]   wc_q  [DEPTH];
  logic [AW-1:0]   stage_q;
  logic [IW-1:0]   wr_idx_q, rd_idx_q;
  logic [CNTW-1:0] count_q;
  logic            push_ok, pop_ok;

  assign pop_ok  = pop_i && (count_q != '0);
  assign push_ok = push_i && ((count_q != CNTW'(DEPTH)) || pop_ok);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        ptr_q[i] <= '0;
        wc_q[i]  <= '0;
      end
      stage_q  <= '0;
      wr_idx_q <= '0;
      rd_idx_q <= '0;
      count_q  <= '0;
    end else begin
      if (stage_we_i) stage_q <= data_i;
      if (push_ok) begin
        ptr_q[wr_idx_q] <= stage_q;
        wc_q[wr_idx_q]  <= data_i[CW-1:0];
        wr_idx_q <= (wr_idx_q == IW'(DEPTH - 1)) ? '0 : wr_idx_q + 1'b1;
      end
      if (pop_ok) rd_idx_q <= (rd_idx_q == IW'(DEPTH - 1)) ? '0 : rd_idx_q + 1'b1;
      count_q <= count_q + CNTW'(push_ok) - CNTW'(pop_ok);
    end
  end

  assign head_ptr_o = ptr_q[rd_idx_q];
  assign head_wc_o  = wc_q[rd_idx_q];
  assign count_o    = count_q;

  // R11: the manager never takes an entry from an empty table
  assert_no_empty_pop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (count_q != '0));
  assert_count_bound_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_q <= CNTW'(DEPTH));
endmodule

// File: rtl/rbm_frame_writer.sv
module rbm_frame_writer import rbm_pkg::*; #(
  parameter int unsigned AW = 16,
  parameter int unsigned CW = 12,
  parameter int unsigned BW = CW + 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode32_i,
  input  logic          blocked_i,
  input  logic [AW-1:0] base_i,
  input  logic [CW-1:0] words_i,
  input  logic          rx_valid_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic [7:0]    rx_data_i,
  input  logic [31:0]   rx_fcs_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o,
  output logic          ready_o,
  output logic          done_o,
  output logic [CW-1:0] used_o,
  output logic          over_o
);
  wr_state_e     st_q;
  logic [BW-1:0] bcnt_q, cur_cnt, cap_b, mask_w, off_w;
  logic          ovf_q, ovf_cur, ovf_nxt, fits, start_ok, take, tail_end;
  logic [31:0]   fcs_q;
  logic [2:0]    tcnt_q;
  logic          done_q, over_q;
  logic [CW-1:0] used_q;
  logic [7:0]    tail_byte;

  assign cap_b    = mode32_i ? {1'b0, words_i, 2'b00} : {2'b00, words_i, 1'b0};
  assign mask_w   = mode32_i ? BW'(3) : BW'(1);
  assign ready_o  = (st_q == WS_IDLE) && !done_q;
  assign start_ok = rx_valid_i && rx_sof_i && ready_o;
  assign take     = (start_ok && !blocked_i) || ((st_q == WS_RECV) && rx_valid_i);
  assign cur_cnt  = (st_q == WS_RECV) ? bcnt_q : '0;
  // room must remain for the check bytes
  assign fits     = (cur_cnt + BW'(FCS_BYTES + 1)) <= cap_b;
  assign ovf_cur  = (st_q == WS_RECV) && ovf_q;
  assign ovf_nxt  = ovf_cur || !fits;
  assign tail_byte = (tcnt_q < 3'd4) ? fcs_q[{tcnt_q[1:0], 3'b000} +: 8] : PAD_BYTE;
  assign tail_end = (tcnt_q >= 3'd3) && (((bcnt_q + BW'(1)) & mask_w) == '0);
  assign off_w    = (st_q == WS_TAIL) ? bcnt_q : cur_cnt;

  assign mem_we_o   = (take && fits && !ovf_cur) || (st_q == WS_TAIL);
  assign mem_addr_o = base_i + AW'(off_w);
  assign mem_data_o = (st_q == WS_TAIL) ? tail_byte : rx_data_i;
  assign done_o     = done_q;
  assign used_o     = used_q;
  assign over_o     = over_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= WS_IDLE;
      bcnt_q <= '0;
      ovf_q  <= 1'b0;
      fcs_q  <= '0;
      tcnt_q <= '0;
      done_q <= 1'b0;
      over_q <= 1'b0;
      used_q <= '0;
    end else begin
      done_q <= 1'b0;
      over_q <= 1'b0;
      unique case (st_q)
        WS_IDLE, WS_RECV: begin
          if (st_q == WS_IDLE && start_ok && blocked_i) begin
            if (!rx_eof_i) st_q <= WS_DROP;
          end else if (take) begin
            bcnt_q <= cur_cnt + BW'(1);
            ovf_q  <= ovf_nxt;
            if (rx_eof_i) begin
              fcs_q  <= rx_fcs_i;
              tcnt_q <= '0;
              if (ovf_nxt) begin
                over_q <= 1'b1;
                st_q   <= WS_IDLE;
              end else begin
                st_q <= WS_TAIL;
              end
            end else begin
              st_q <= WS_RECV;
            end
          end
        end
        WS_DROP: if (rx_valid_i && rx_eof_i) st_q <= WS_IDLE;
        WS_TAIL: begin
          bcnt_q <= bcnt_q + BW'(1);
          tcnt_q <= tcnt_q + 3'd1;
          if (tail_end) begin
            done_q <= 1'b1;
            used_q <= CW'((bcnt_q + BW'(1)) >> (mode32_i ? 2 : 1));
            st_q   <= WS_IDLE;
          end
        end
        default: st_q <= WS_IDLE;
      endcase
    end
  end

  // R7: no byte lands beyond the remaining buffer space
  assert_in_buffer_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> (off_w < cap_b));
  // R5: a completed frame ends on a bus word boundary
  assert_tail_aligned_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(mem_we_o) && ((($past(mem_addr_o) + AW'(1)) & AW'(mask_w)) == '0)));
  // R9: a refused frame start writes nothing
  assert_blocked_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_ok && blocked_i) |-> !mem_we_o);
endmodule

// File: rtl/rx_buf_manager.sv
module rx_buf_manager import rbm_pkg::*; #(
  parameter int unsigned AW        = 16,
  parameter int unsigned CW        = 12,
  parameter int unsigned DEPTH     = 4,
  parameter int unsigned EOB_WORDS = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode32_i,
  input  logic          rx_valid_i,
  input  logic          rx_sof_i,
  input  logic          rx_eof_i,
  input  logic [7:0]    rx_data_i,
  input  logic [31:0]   rx_fcs_i,
  output logic          rx_ready_o,
  input  logic          reg_we_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [AW-1:0] reg_wdata_i,
  input  logic          cmd_load_i,
  output logic          mem_we_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_data_o,
  output logic          irq_o,
  output logic [2:0]    irq_status_o,
  output logic          cmd_pend_o,
  output logic          exhausted_o,
  output logic [AW-1:0] buf_addr_o,
  output logic [CW-1:0] buf_words_o,
  output logic [7:0]    pkt_seq_o,
  output logic [7:0]    buf_seq_o
);
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [AW-1:0]   buf_addr_q, head_ptr, aligned_ptr;
  logic [CW-1:0]   buf_words_q, head_wc, wr_used, rwc_after;
  logic [CNTW-1:0] ring_cnt;
  logic [7:0]      pkt_seq_q, buf_seq_q;
  logic [ST_W-1:0] stat_q, mask_q, clr_v, set_v;
  logic            cmd_pend_q, exhausted_q;
  logic            wr_ready, wr_done, wr_over;
  logic            cmd_go, fetch, load_go, exhaust_set;

  rbm_desc_ring #(.DEPTH(DEPTH), .AW(AW), .CW(CW), .CNTW(CNTW)) u_ring (
    .clk_i, .rst_ni,
    .stage_we_i (reg_we_i && reg_sel_i == 2'd0),
    .push_i     (reg_we_i && reg_sel_i == 2'd1),
    .data_i     (reg_wdata_i),
    .pop_i      (load_go),
    .head_ptr_o (head_ptr),
    .head_wc_o  (head_wc),
    .count_o    (ring_cnt)
  );

  rbm_frame_writer #(.AW(AW), .CW(CW)) u_wr (
    .clk_i, .rst_ni,
    .mode32_i, .blocked_i (exhausted_q),
    .base_i (buf_addr_q), .words_i (buf_words_q),
    .rx_valid_i, .rx_sof_i, .rx_eof_i, .rx_data_i, .rx_fcs_i,
    .mem_we_o, .mem_addr_o, .mem_data_o,
    .ready_o (wr_ready), .done_o (wr_done), .used_o (wr_used), .over_o (wr_over)
  );

  assign aligned_ptr = mode32_i ? {head_ptr[AW-1:2], 2'b00} : {head_ptr[AW-1:1], 1'b0};
  assign rwc_after   = buf_words_q - wr_used;
  // command loads only between frames so the writer never sees a base change mid-frame
  assign cmd_go      = cmd_pend_q && (ring_cnt != '0) && wr_ready && !rx_valid_i;
  assign fetch       = wr_done && (rwc_after < CW'(EOB_WORDS));
  assign load_go     = cmd_go || (fetch && ring_cnt != '0);
  assign exhaust_set = fetch && (ring_cnt == '0);

  assign clr_v = (reg_we_i && reg_sel_i == 2'd2) ? reg_wdata_i[ST_W-1:0] : '0;
  always_comb begin
    set_v          = '0;
    set_v[ST_PKT]  = wr_done;
    set_v[ST_WARN] = load_go && (ring_cnt == CNTW'(1));
    set_v[ST_OVER] = wr_over;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_addr_q  <= '0;
      buf_words_q <= '0;
      pkt_seq_q   <= '0;
      buf_seq_q   <= '0;
      stat_q      <= '0;
      mask_q      <= '0;
      cmd_pend_q  <= 1'b0;
      exhausted_q <= 1'b1;
    end else begin
      if (cmd_load_i)  cmd_pend_q <= 1'b1;
      else if (cmd_go) cmd_pend_q <= 1'b0;
      if (load_go) begin
        buf_addr_q  <= aligned_ptr;
        buf_words_q <= head_wc;
        buf_seq_q   <= buf_seq_q + 8'd1;
        exhausted_q <= 1'b0;
      end else if (wr_done) begin
        buf_addr_q  <= buf_addr_q + (AW'(wr_used) << (mode32_i ? 2 : 1));
        buf_words_q <= rwc_after;
      end
      if (exhaust_set) exhausted_q <= 1'b1;
      if (wr_done) pkt_seq_q <= pkt_seq_q + 8'd1;
      if (reg_we_i && reg_sel_i == 2'd3) mask_q <= reg_wdata_i[ST_W-1:0];
      stat_q <= (stat_q & ~clr_v) | set_v;
    end
  end

  assign rx_ready_o   = wr_ready;
  assign irq_o        = |(stat_q & mask_q);
  assign irq_status_o = stat_q;
  assign cmd_pend_o   = cmd_pend_q;
  assign exhausted_o  = exhausted_q;
  assign buf_addr_o   = buf_addr_q;
  assign buf_words_o  = buf_words_q;
  assign pkt_seq_o    = pkt_seq_q;
  assign buf_seq_o    = buf_seq_q;

  for (genvar gi = 0; gi < ST_W; gi++) begin : g_sticky
    assert_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[gi] && !clr_v[gi]) |=> stat_q[gi]);
  end
  assert_cmd_clear_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cmd_pend_q) |-> $past(ring_cnt != '0));
  assert_addr_even_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_addr_q[0] == 1'b0);
  assert_words_shrink_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_go |=> (buf_words_q <= $past(buf_words_q)));
endmodule

// File: tb/sim_rx_buf_manager.sv
`timescale 1ns/1ps
module sim_rx_buf_manager;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        m32 = 1'b0;
  logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0;
  logic [7:0]  rx_data = '0;
  logic [31:0] rx_fcs = '0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_sel = '0;
  logic [15:0] reg_wdata = '0;
  logic        cmd_load = 1'b0;
  logic        rx_ready_o, mem_we_o, irq_o, cmd_pend_o, exhausted_o;
  logic [15:0] mem_addr_o, buf_addr_o;
  logic [7:0]  mem_data_o, pkt_seq_o, buf_seq_o;
  logic [2:0]  irq_status_o;
  logic [11:0] buf_words_o;

  int checks = 0, errors = 0, nwr = 0;
  logic [7:0] bmem [0:1023];
  int m_addr = 0, m_rwc = 0, m_pseq = 0;

  always #4 clk = ~clk;

  rx_buf_manager u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode32_i(m32),
    .rx_valid_i(rx_valid), .rx_sof_i(rx_sof), .rx_eof_i(rx_eof),
    .rx_data_i(rx_data), .rx_fcs_i(rx_fcs), .rx_ready_o,
    .reg_we_i(reg_we), .reg_sel_i(reg_sel), .reg_wdata_i(reg_wdata),
    .cmd_load_i(cmd_load), .mem_we_o, .mem_addr_o, .mem_data_o,
    .irq_o, .irq_status_o, .cmd_pend_o, .exhausted_o,
    .buf_addr_o, .buf_words_o, .pkt_seq_o, .buf_seq_o
  );

  always @(negedge clk) if (mem_we_o) begin
    bmem[mem_addr_o[9:0]] = mem_data_o;
    nwr++;
  end

  task automatic tick(); @(posedge clk); #1; endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [1:0] sel, input logic [15:0] d);
    reg_we = 1'b1; reg_sel = sel; reg_wdata = d; tick(); reg_we = 1'b0;
  endtask

  task automatic push_desc(input logic [15:0] p, input logic [15:0] wc);
    reg_wr(2'd0, p); reg_wr(2'd1, wc);
  endtask

  task automatic do_cmd(); cmd_load = 1'b1; tick(); cmd_load = 1'b0; repeat (3) tick(); endtask

  function automatic logic [7:0] pay(input int len, input int i);
    return 8'(len * 7 + i + 48);
  endfunction

  task automatic send_frame(input int len);
    while (!rx_ready_o) tick();
    nwr = 0;
    for (int i = 0; i < len; i++) begin
      rx_valid = 1'b1; rx_sof = (i == 0); rx_eof = (i == len - 1);
      rx_data = pay(len, i); rx_fcs = 32'hA1B2C300 + 32'(len);
      tick();
    end
    rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0;
    repeat (12) tick();
  endtask

  task automatic check_frame(input int len, input bit reload, input int nptr, input int nwc);
    int bpw = m32 ? 4 : 2;
    int tot = ((len + 4 + bpw - 1) / bpw) * bpw;
    int bad_d = 0, bad_p = 0;
    logic [31:0] f = 32'hA1B2C300 + 32'(len);
    for (int i = 0; i < tot; i++) begin
      logic [7:0] e;
      e = (i < len) ? pay(len, i) : (i < len + 4) ? f[8*(i-len) +: 8] : 8'hFF;
      if (bmem[10'(m_addr + i)] !== e) begin
        if (i < len + 4) bad_d++; else bad_p++;
      end
    end
    chk("R4 payload and check bytes mismatches", bad_d, 0);
    chk("R5 pad byte mismatches", bad_p, 0);
    chk("R5 bytes written", nwr, tot);
    m_pseq++;
    m_addr += tot;
    m_rwc -= tot / bpw;
    if (reload) begin m_addr = nptr; m_rwc = nwc; end
    chk("R6 buffer address", buf_addr_o, m_addr);
    chk("R6 word count", buf_words_o, m_rwc);
    chk("R6 frame sequence", pkt_seq_o, m_pseq);
    chk("R6 stored status bit", irq_status_o[0], 1'b1);
  endtask

  initial begin
    #(8 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 1024; i++) bmem[i] = 8'h00;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();
    chk("R1 exhausted", exhausted_o, 1'b1);
    chk("R1 status", irq_status_o, 3'b000);
    chk("R1 irq", irq_o, 1'b0);
    chk("R1 pending", cmd_pend_o, 1'b0);
    chk("R1 words", buf_words_o, 0);
    chk("R1 ready", rx_ready_o, 1'b1);

    send_frame(6);
    chk("R9 no writes while exhausted", nwr, 0);
    chk("R9 sequence unchanged", pkt_seq_o, 0);

    do_cmd();
    chk("R3 pending with empty table", cmd_pend_o, 1'b1);
    chk("R3 nothing loaded", buf_seq_o, 0);

    // 16-bit mode
    push_desc(16'h0101, 16'd64);
    repeat (3) tick();
    chk("R2 16-bit alignment", buf_addr_o, 16'h0100);
    chk("R2 words loaded", buf_words_o, 64);
    chk("R2 buffer sequence", buf_seq_o, 1);
    chk("R3 pending cleared on load", cmd_pend_o, 1'b0);
    chk("R8 warning on last entry", irq_status_o[1], 1'b1);
    chk("R9 exhausted cleared", exhausted_o, 1'b0);
    reg_wr(2'd3, 16'h0002);
    chk("R10 irq from masked warning", irq_o, 1'b1);
    reg_wr(2'd2, 16'h0002);
    chk("R10 w1c clears bit", irq_status_o, 3'b000);
    chk("R10 irq drops", irq_o, 1'b0);
    m_addr = 16'h0100; m_rwc = 64;
    for (int l = 1; l <= 5; l++) begin
      send_frame(l);
      check_frame(l, 1'b0, 0, 0);
    end

    // 32-bit mode
    m32 = 1'b1;
    push_desc(16'h0203, 16'd20);
    do_cmd();
    chk("R2 32-bit alignment", buf_addr_o, 16'h0200);
    chk("R2 words loaded 32", buf_words_o, 20);
    chk("R8 warning again", irq_status_o[1], 1'b1);
    reg_wr(2'd2, 16'h0007);
    m_addr = 16'h0200; m_rwc = 20;
    for (int l = 1; l <= 5; l++) begin
      send_frame(l);
      check_frame(l, 1'b0, 0, 0);
    end
    chk("R8 reception continued after warning", pkt_seq_o, 10);

    // oversize: 9 words = 36 bytes, 33+4 does not fit
    reg_wr(2'd2, 16'h0007);
    send_frame(33);
    chk("R7 bytes written before drop", nwr, 32);
    chk("R7 address unchanged", buf_addr_o, m_addr);
    chk("R7 words unchanged", buf_words_o, m_rwc);
    chk("R7 sequence unchanged", pkt_seq_o, m_pseq);
    chk("R7 oversize status", irq_status_o, 3'b100);
    reg_wr(2'd3, 16'h0004);
    chk("R10 irq from oversize", irq_o, 1'b1);
    reg_wr(2'd2, 16'h0007);
    chk("R10 oversize cleared", irq_o, 1'b0);

    send_frame(12);
    check_frame(12, 1'b0, 0, 0);
    send_frame(1);
    check_frame(1, 1'b0, 0, 0);
    chk("R9 exhausted on empty fetch", exhausted_o, 1'b1);
    send_frame(4);
    chk("R9 dropped frame writes", nwr, 0);
    chk("R9 dropped frame sequence", pkt_seq_o, m_pseq);

    reg_wr(2'd2, 16'h0007);
    push_desc(16'h0300, 16'd8);
    push_desc(16'h0341, 16'd8);
    do_cmd();
    chk("R2 load from two entries", buf_addr_o, 16'h0300);
    chk("R8 no warning with entries left", irq_status_o[1], 1'b0);
    m_addr = 16'h0300; m_rwc = 8;
    send_frame(20);
    check_frame(20, 1'b1, 16'h0340, 8);
    chk("R8 auto fetch warning", irq_status_o[1], 1'b1);
    chk("R8 exhausted stays clear", exhausted_o, 1'b0);
    chk("R2 buffer sequence after fetch", buf_seq_o, 4);

    // fifth entry lands in wrapped slot
    push_desc(16'h0381, 16'd16);
    send_frame(16);
    check_frame(16, 1'b1, 16'h0380, 16);
    chk("R11 wrapped entry loaded", buf_seq_o, 5);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule